// File: doc/BRIEF.md
# 8-bit Single-Cycle Processor

This block is a small 8-bit processor that completes one instruction on every clock edge. It reads an 8-bit instruction at the program counter from a private instruction array. It decodes the instruction and updates four general registers, a single compare flag, a private data array and the program counter, all on the same edge. Branches take their absolute target from register r0 and test the compare flag.

The instruction array is filled by the surrounding environment while reset is held. Reset is synchronous. After reset is released the core runs until it executes a stop instruction. From then on it is frozen until the next reset. Three outputs make progress visible: the program counter, a halted indication and a 16-bit count of executed instructions. Programs therefore report their outcome through the address at which they stop.

Top module: `cpu8_core`

## Requirements
- R1: Instruction encoding. If bits [7:6] are 00, the instruction writes the zero-extended immediate in bits [3:0] into the register selected by bits [5:4]. Otherwise bits [7:4] are the opcode, bits [3:2] select rd and bits [1:0] select rs. The opcodes are: 4 mov, 5 add, 6 sub, 7 xor, 8 shl4, 9 ushr4, A ld, B st, C cmpeq, D cmphi, E branch, F halt.
- R2: While reset is sampled high on a clock edge, that edge sets the program counter to 0, clears the instruction counter, halted, the flag and all four registers.
- R3: mov copies rs into rd. add and sub compute rd+rs and rd-rs modulo 256. xor computes rd^rs. No carry is kept.
- R4: shl4 writes rs shifted left by four into rd, dropping the upper bits. ushr4 writes rs shifted right by four into rd, filling with zeros.
- R5: ld writes the data byte at the address held in rs into rd. st writes rd into the data byte at the address held in rs.
- R6: cmpeq sets the flag to (rd == rs). cmphi sets the flag to (rd > rs) as an unsigned comparison. Neither writes a register.
- R7: Opcode E selects its condition from bits [1:0]: 00 always, 01 when the flag is 1, 10 when the flag is 0, 11 never. When taken, the next PC is the value of r0. A branch never changes the flag.
- R8: Every instruction other than a taken branch or halt advances the PC by exactly 1.
- R9: Halt sets the halted output and holds the PC at the halt's own address. After that, PC, counter, registers, flag and data memory do not change until reset.
- R10: The 16-bit instruction counter increases by one for every executed instruction, halt included, and then stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc | output | IMEM_AW (8) | Address of the instruction being executed |
| halted | output | 1 | High once a halt has executed |
| instrCount | output | CNT_W (16) | Number of instructions executed since reset |

## Verification
The checker watches the sequencing rules on every cycle. These are the PC step of one on ordinary instructions, an unconditional branch landing on r0, the flag holding across any branch, the halt entry and freeze, no stores while halted, the one-per-cycle counter step and the zero state just after reset. The arithmetic results, shifts, memory round trips, compare outcomes and conditional branch decisions can only be shown by the bench's directed programs. Each program compares its own results with cmpeq and branches to a failure stop at address 2 on a mismatch. The bench then reads the stop address and the counter at the ports.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int DATA_W    = 8;
  localparam int REG_N     = 4;
  localparam int REG_IDX_W = $clog2(REG_N);
  localparam int IMM_W     = 4;

  typedef enum logic [3:0] {
    OP_MOV   = 4'h4,
    OP_ADD   = 4'h5,
    OP_SUB   = 4'h6,
    OP_XOR   = 4'h7,
    OP_SHL4  = 4'h8,
    OP_USHR4 = 4'h9,
    OP_LD    = 4'hA,
    OP_ST    = 4'hB,
    OP_CMPEQ = 4'hC,
    OP_CMPHI = 4'hD,
    OP_BR    = 4'hE,
    OP_HALT  = 4'hF
  } opcodeE;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_XOR,
    ALU_SHL4,
    ALU_SHR4
  } aluOpE;

  typedef enum logic [1:0] {
    COND_ALWAYS = 2'b00,
    COND_FLAG   = 2'b01,
    COND_NOFLAG = 2'b10,
    COND_NEVER  = 2'b11
  } condE;

  // Strobes and operand fields handed from control to datapath
  typedef struct packed {
    logic                 regWrite;
    logic                 memWrite;
    logic                 flagWrite;
    logic                 cmpHi;
    logic                 useImm;
    logic                 wbFromMem;
    logic                 branch;
    condE                 cond;
    logic                 halt;
    aluOpE                aluOp;
    logic [REG_IDX_W-1:0] rdIdx;
    logic [REG_IDX_W-1:0] rsIdx;
    logic [IMM_W-1:0]     imm;
  } ctrlS;

endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluOpE             op,
  output logic [DATA_W-1:0] result,
  output logic              isEq,
  output logic              isHi
);

  localparam int NIB = DATA_W / 2;

  always_comb begin
    unique case (op)
      ALU_ADD:  result = opA + opB;
      ALU_SUB:  result = opA - opB;
      ALU_XOR:  result = opA ^ opB;
      ALU_SHL4: result = opB << NIB;
      ALU_SHR4: result = opB >> NIB;
      default:  result = opB;
    endcase
  end

  assign isEq = (opA == opB);
  assign isHi = (opA > opB);

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  input  logic              halted,
  output ctrlS              ctrl
);

  ctrlS decoded;
  logic immForm;

  assign immForm = (instr[7:6] == 2'b00);

  always_comb begin
    decoded       = '0;
    decoded.cond  = COND_NEVER;
    decoded.aluOp = ALU_PASS;
    decoded.imm   = instr[IMM_W-1:0];
    if (immForm) begin
      decoded.rdIdx    = instr[5:4];
      decoded.useImm   = 1'b1;
      decoded.regWrite = 1'b1;
    end else begin
      decoded.rdIdx = instr[3:2];
      decoded.rsIdx = instr[1:0];
      unique case (opcodeE'(instr[7:4]))
        OP_MOV:   decoded.regWrite = 1'b1;
        OP_ADD:   begin decoded.regWrite = 1'b1; decoded.aluOp = ALU_ADD;  end
        OP_SUB:   begin decoded.regWrite = 1'b1; decoded.aluOp = ALU_SUB;  end
        OP_XOR:   begin decoded.regWrite = 1'b1; decoded.aluOp = ALU_XOR;  end
        OP_SHL4:  begin decoded.regWrite = 1'b1; decoded.aluOp = ALU_SHL4; end
        OP_USHR4: begin decoded.regWrite = 1'b1; decoded.aluOp = ALU_SHR4; end
        OP_LD:    begin decoded.regWrite = 1'b1; decoded.wbFromMem = 1'b1; end
        OP_ST:    decoded.memWrite = 1'b1;
        OP_CMPEQ: decoded.flagWrite = 1'b1;
        OP_CMPHI: begin decoded.flagWrite = 1'b1; decoded.cmpHi = 1'b1; end
        OP_BR:    begin decoded.branch = 1'b1; decoded.cond = condE'(instr[1:0]); end
        OP_HALT:  decoded.halt = 1'b1;
        default:  decoded.halt = 1'b0;
      endcase
    end
  end

  // A frozen machine issues no side effects at all
  always_comb begin
    ctrl = decoded;
    if (halted) begin
      ctrl.regWrite  = 1'b0;
      ctrl.memWrite  = 1'b0;
      ctrl.flagWrite = 1'b0;
      ctrl.branch    = 1'b0;
      ctrl.halt      = 1'b0;
    end
  end

endmodule

// File: rtl/cpu8_dpath.sv
module cpu8_dpath
  import cpu8_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlS               ctrl,
  input  logic [DATA_W-1:0]  dmemRdata,
  output logic [IMEM_AW-1:0] pc,
  output logic [DMEM_AW-1:0] dmemAddr,
  output logic [DATA_W-1:0]  dmemWdata,
  output logic               halted,
  output logic [CNT_W-1:0]   instrCount
);

  logic [DATA_W-1:0] regFile [REG_N];
  logic              flag;
  logic [DATA_W-1:0] rdVal, rsVal, aluB, aluY, wbData;
  logic              eq, hi, taken;
  logic [IMEM_AW-1:0] pcNext;

  assign rdVal = regFile[ctrl.rdIdx];
  assign rsVal = regFile[ctrl.rsIdx];

  // Operand mux: register or zero-extended immediate
  assign aluB = ctrl.useImm ? DATA_W'(ctrl.imm) : rsVal;

  cpu8_alu u_alu (
    .opA    (rdVal),
    .opB    (aluB),
    .op     (ctrl.aluOp),
    .result (aluY),
    .isEq   (eq),
    .isHi   (hi)
  );

  // Write-back mux: ALU or data memory
  assign wbData    = ctrl.wbFromMem ? dmemRdata : aluY;
  assign dmemAddr  = rsVal[DMEM_AW-1:0];
  assign dmemWdata = rdVal;

  always_comb begin
    unique case (ctrl.cond)
      COND_ALWAYS: taken = ctrl.branch;
      COND_FLAG:   taken = ctrl.branch & flag;
      COND_NOFLAG: taken = ctrl.branch & ~flag;
      default:     taken = 1'b0;
    endcase
  end

  always_comb begin
    if (halted || ctrl.halt) pcNext = pc;
    else if (taken)          pcNext = regFile[0][IMEM_AW-1:0];
    else                     pcNext = pc + 1'b1;
  end

  generate
    for (genvar g = 0; g < REG_N; g++) begin : gen_reg
      always_ff @(posedge clk) begin
        if (rst)
          regFile[g] <= '0;
        else if (ctrl.regWrite && ctrl.rdIdx == REG_IDX_W'(g))
          regFile[g] <= wbData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      halted     <= 1'b0;
      flag       <= 1'b0;
      instrCount <= '0;
    end else begin
      pc <= pcNext;
      if (!halted) instrCount <= instrCount + 1'b1;
      if (ctrl.halt) halted <= 1'b1;
      if (ctrl.flagWrite) flag <= ctrl.cmpHi ? hi : eq;
    end
  end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IMEM_AW-1:0] pc,
  output logic               halted,
  output logic [CNT_W-1:0]   instrCount
);

  localparam int IMEM_DEPTH = 1 << IMEM_AW;
  localparam int DMEM_DEPTH = 1 << DMEM_AW;

  logic [DATA_W-1:0] instrMem [IMEM_DEPTH];
  logic [DATA_W-1:0] dataMem  [DMEM_DEPTH];

  logic [DATA_W-1:0]  instr;
  ctrlS               ctrl;
  logic [DMEM_AW-1:0] dmemAddr;
  logic [DATA_W-1:0]  dmemWdata, dmemRdata;
  logic               dmemWe;

  // Unloaded locations hold a stop instruction
  initial begin
    for (int i = 0; i < IMEM_DEPTH; i++) instrMem[i] = {OP_HALT, 4'h0};
  end

  assign instr = instrMem[pc];

  cpu8_ctrl u_ctrl (
    .instr  (instr),
    .halted (halted),
    .ctrl   (ctrl)
  );

  cpu8_dpath #(
    .IMEM_AW (IMEM_AW),
    .DMEM_AW (DMEM_AW),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .dmemRdata  (dmemRdata),
    .pc         (pc),
    .dmemAddr   (dmemAddr),
    .dmemWdata  (dmemWdata),
    .halted     (halted),
    .instrCount (instrCount)
  );

  assign dmemWe    = ctrl.memWrite;
  assign dmemRdata = dataMem[dmemAddr];

  always_ff @(posedge clk) begin
    if (dmemWe) dataMem[dmemAddr] <= dmemWdata;
  end

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk #(
  parameter int IMEM_AW = 8,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [IMEM_AW-1:0] pc,
  input logic               halted,
  input logic [CNT_W-1:0]   instrCount,
  input logic [7:0]         instr,
  input logic               dmemWe,
  input logic [7:0]         r0Val,
  input logic               flag
);

  logic prevRst = 1'b0;
  logic isBr, isHalt;

  assign isBr   = (instr[7:4] == 4'hE);
  assign isHalt = (instr[7:4] == 4'hF);

  // R2: the edge after a reset edge sees the cleared state
  always_ff @(posedge clk) begin
    if (prevRst)
      assert_reset_clears_R2: assert (pc == '0 && instrCount == '0 && !halted)
        else $error("reset state not cleared");
    prevRst <= rst;
  end

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!halted && !isBr && !isHalt) |=> pc == IMEM_AW'($past(pc) + 1'b1));

  assert_jmp_target_R7: assert property (@(posedge clk) disable iff (rst)
    (!halted && isBr && instr[1:0] == 2'b00) |=> pc == $past(r0Val[IMEM_AW-1:0]));

  assert_branch_keeps_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (!halted && isBr) |=> $stable(flag));

  assert_halt_enter_R9: assert property (@(posedge clk) disable iff (rst)
    (!halted && isHalt) |=> halted && $stable(pc));

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(instrCount) && $stable(flag));

  assert_halt_no_store_R9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmemWe);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    !halted |=> instrCount == CNT_W'($past(instrCount) + 1'b1));

endmodule

bind cpu8_core cpu8_core_chk #(
  .IMEM_AW (IMEM_AW),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc         (pc),
  .halted     (halted),
  .instrCount (instrCount),
  .instr      (instr),
  .dmemWe     (dmemWe),
  .r0Val      (u_dp.regFile[0]),
  .flag       (u_dp.flag)
);

// File: tb/cpu8_core_bench.sv
module cpu8_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FAIL_PC    = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pc;
  logic        halted;
  logic [15:0] instrCount;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cpu8_core u_cpu8_core (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc),
    .halted     (halted),
    .instrCount (instrCount)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [7:0] v);
    u_cpu8_core.instrMem[a] = v;
  endtask

  // Hold reset, fill with stops, write the common prologue:
  // 0: r0=3, 1: jmp r0, 2: failure stop
  task automatic beginProg();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) put(i, 8'hF0);
    put(0, 8'h03); put(1, 8'hE0); put(2, 8'hF0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runProg(input string req, input int passPc, input int expCnt);
    rst = 1'b0;
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
    check(req, "halted", int'(halted), 1);
    check(req, "stop pc", int'(pc), passPc);
    check(req, "count", int'(instrCount), expCnt);
  endtask

  // R1 R3 R8: mov-imm, add/sub wrap, xor, mov
  task automatic testAlu();
    beginProg();
    put(3, 8'h19); put(4, 8'h2F); put(5, 8'h56); put(6, 8'h31);
    put(7, 8'h8F); put(8, 8'h67); put(9, 8'h38); put(10, 8'hC7);
    put(11, 8'h02); put(12, 8'hE2);
    put(13, 8'h10); put(14, 8'h66); put(15, 8'h76); put(16, 8'h56);
    put(17, 8'h3D); put(18, 8'hC7); put(19, 8'h02); put(20, 8'hE2);
    put(21, 8'h4E); put(22, 8'hCE); put(23, 8'h02); put(24, 8'hE2);
    put(25, 8'hF0);
    runProg("R3", 25, 25);
  endtask

  // R2: reset from a halted state clears outputs; registers and flag read back zero
  task automatic testReset();
    beginProg();
    check("R2", "pc in reset", int'(pc), 0);
    check("R2", "count in reset", int'(instrCount), 0);
    check("R2", "halted in reset", int'(halted), 0);
    put(3, 8'h02); put(4, 8'hE1);
    put(5, 8'h30); put(6, 8'hC7); put(7, 8'h02); put(8, 8'hE2);
    put(9, 8'hCB); put(10, 8'h02); put(11, 8'hE2); put(12, 8'hF0);
    runProg("R2", 12, 12);
  endtask

  // R10 R8: counter and PC part way through a run
  task automatic testProgress();
    beginProg();
    put(3, 8'h19); put(4, 8'h2F); put(5, 8'h56); put(6, 8'hF0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R10", "count after 5 edges", int'(instrCount), 5);
    check("R8", "pc after 5 edges", int'(pc), 6);
    check("R9", "not yet halted", int'(halted), 0);
    @(negedge clk);
    check("R10", "count incl. halt", int'(instrCount), 6);
    check("R9", "halt pc", int'(pc), 6);
  endtask

  // R4: shifts
  task automatic testShift();
    beginProg();
    put(3, 8'h1A); put(4, 8'h89); put(5, 8'h9E); put(6, 8'hCD);
    put(7, 8'h02); put(8, 8'hE2);
    put(9, 8'h8E); put(10, 8'h10); put(11, 8'hCD); put(12, 8'h02); put(13, 8'hE2);
    put(14, 8'h1F); put(15, 8'h85); put(16, 8'h95); put(17, 8'h3F);
    put(18, 8'hC7); put(19, 8'h02); put(20, 8'hE2); put(21, 8'hF0);
    runProg("R4", 21, 21);
  endtask

  // R5: store then load back at two addresses
  task automatic testMem();
    beginProg();
    put(3, 8'h17); put(4, 8'h25); put(5, 8'hB6); put(6, 8'h3C);
    put(7, 8'h26); put(8, 8'hBE); put(9, 8'h25); put(10, 8'hAE);
    put(11, 8'hCD); put(12, 8'h02); put(13, 8'hE2);
    put(14, 8'h26); put(15, 8'hA6); put(16, 8'h3C); put(17, 8'hC7);
    put(18, 8'h02); put(19, 8'hE2); put(20, 8'hF0);
    runProg("R5", 20, 20);
  endtask

  // R6: cmphi true/false/equal/unsigned, compares write no register
  task automatic testCompare();
    beginProg();
    put(3, 8'h19); put(4, 8'h23); put(5, 8'hD6); put(6, 8'h02); put(7, 8'hE2);
    put(8, 8'hD9); put(9, 8'h02); put(10, 8'hE1);
    put(11, 8'hD5); put(12, 8'h02); put(13, 8'hE1);
    put(14, 8'h38); put(15, 8'h8F); put(16, 8'hDD); put(17, 8'h02); put(18, 8'hE2);
    put(19, 8'h39); put(20, 8'hC7); put(21, 8'h02); put(22, 8'hE2);
    put(23, 8'hC6); put(24, 8'h02); put(25, 8'hE1); put(26, 8'hF0);
    runProg("R6", 26, 26);
  endtask

  // R7: jmpt taken, flag kept, jmpf taken, jmp to computed r0
  task automatic testBranch();
    beginProg();
    put(3, 8'h14); put(4, 8'hC5); put(5, 8'h08); put(6, 8'hE1); put(7, 8'hF0);
    put(8, 8'h02); put(9, 8'hE2); put(10, 8'hC4); put(11, 8'h0E); put(12, 8'hE2);
    put(13, 8'hF0);
    put(14, 8'h02); put(15, 8'hE1); put(16, 8'h31); put(17, 8'h83);
    put(18, 8'h36); put(19, 8'h53); put(20, 8'hE0); put(21, 8'hF0); put(22, 8'hF0);
    runProg("R7", 22, 19);
  endtask

  // R9: halt at address 0 freezes PC and counter
  task automatic testHaltFreeze();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) put(i, 8'hF0);
    put(1, 8'h01);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "halted after 1 edge", int'(halted), 1);
    check("R10", "count incl. halt", int'(instrCount), 1);
    repeat (20) @(negedge clk);
    check("R9", "pc frozen", int'(pc), 0);
    check("R9", "count frozen", int'(instrCount), 1);
    check("R9", "still halted", int'(halted), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R1..all: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    testAlu();
    testReset();
    testProgress();
    testShift();
    testMem();
    testCompare();
    testBranch();
    testHaltFreeze();
    check("R1", "never hit failure stop", int'(pc == 8'(FAIL_PC)), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule